// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real-time clock. It holds eight 8-bit registers in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. An external prescaler supplies a one-cycle `tick_100hz` enable once every hundredth of a second. On each tick the hundredths field advances, and each field carries into the next one, up through the year. Hours follow either a 24-hour or a 12-hour count with an AM/PM flag. The date wraps at the true length of the current month, and February has 29 days in leap years.

An access controller reads the whole register file at once on `cal_rd`. It writes all eight registers in a single cycle through `cal_load_en` and `cal_load`. Two control flags sit in otherwise unused bits of the day register. One stops the count. The other is stored for the access controller's use. Bits that have no meaning are forced to zero when a value is loaded.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After a synchronous reset the read bus is 64'h0001_0101_0000_0000: year 00, month 01, date 01, day register 01, and hours, minutes, seconds and hundredths all 00. The hours value 00 means 24-hour mode.
- R2: Bus byte 0 (hundredths, 00–99), byte 1 (seconds, 00–59, bits 6:0) and byte 2 (minutes, 00–59, bits 6:0) count in BCD. Each wraps to 00 at its top value and carries into the next field.
- R3: Byte 3 holds the hours. With byte 3 bit 7 = 0 (24-hour mode), bits 5:0 count 00–23 in BCD. A minute carry at 23 gives 00 and carries into the day of week and the date.
- R4: With byte 3 bit 7 = 1 (12-hour mode), bits 4:0 count 01–12 and bit 5 is the PM flag (1 = PM). 11 goes to 12 and toggles the flag. 12 goes to 01. Only the step from PM 11 to AM 12 carries into the day of week and the date. Bit 7 keeps its value while the clock counts.
- R5: Byte 5 (date, bits 5:0) wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in February of a non-leap year. The wrap carries into byte 6.
- R6: A year in byte 7 whose value is divisible by 4 is a leap year, and this includes 00. In a leap year, February 28 is followed by February 29.
- R7: Byte 4 bits 2:0 (day of week) go from 7 to 1 on a date carry. Byte 6 (month, bits 4:0) goes from 12 to 01 and carries into byte 7. Byte 7 (year) goes from 99 to 00.
- R8: Byte 4 bit 5 stops the count: when it is 1, ticks change nothing. Byte 4 bit 4 is a stored flag that keeps its value while the clock counts.
- R9: Bits that are always zero read back as 0 whatever was loaded: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7:6, and byte 6 bits 7:5.
- R10: When `cal_load_en` is high, the read bus on the next cycle equals the loaded value with the zero bits cleared. A tick in the same cycle is ignored.
- R11: When `tick_100hz` is low and no load is in progress, the read bus holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle enable, once every hundredth of a second |
| cal_load_en | input | 1 | Parallel load strobe |
| cal_load | input | 64 | Load value; byte n is register n |
| cal_rd | output | 64 | Current register file; byte n is register n |

## Verification
Each check loads a full register image and then applies exactly one tick. The image is chosen so that this single tick stops at a different level of the carry chain: a plain digit step, a step across a BCD nibble, and wraps at the minute, the hour and the day. The day-level images use every month length, leap and non-leap years (00, 10, 12, 23, 24) and the 7-to-1 and year 99 wraps, so each one shows whether the date limit comes from the right month and year. The 12-hour images cover 11 AM, 12 PM and 11 PM, which tells a correct PM toggle apart from a wrong day carry. Separate tests cover the stopped oscillator, ticks held low, an all-ones load for the zero bits, and a load that arrives together with a tick.

// File: rtl/clkcal_pkg.sv
`timescale 1ns/1ps
package clkcal_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int BUS_W    = REG_W * NUM_REGS;
    localparam int NUM_TIME = 3;

    typedef logic [REG_W-1:0] bcd8_t;

    typedef struct packed {
        bcd8_t year;
        bcd8_t month;
        bcd8_t date;
        bcd8_t day;
        bcd8_t hour;
        bcd8_t minute;
        bcd8_t second;
        bcd8_t centi;
    } cal_regs_t;

    // bits that may hold a 1; everything else reads as zero
    localparam logic [BUS_W-1:0] KEEP_MASK = 64'hFF1F_3F37_BF7F_7FFF;

    // top values of the sub-minute chain: hundredths, seconds, minutes
    localparam bcd8_t TIME_TOP [NUM_TIME] = '{8'h99, 8'h59, 8'h59};

    function automatic bcd8_t bcd_step(bcd8_t v);
        bcd8_t r;
        if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'h1};
        return r;
    endfunction

    function automatic int bcd_value(bcd8_t v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
        bcd8_t r;
        case (mon)
            8'h02:   r = ((bcd_value(yr) % 4) == 0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default: r = 8'h31;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/clkcal_field.sv
`timescale 1ns/1ps
module clkcal_field import clkcal_pkg::*; #(
    parameter bcd8_t LO      = 8'h00,
    parameter bcd8_t RST_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  logic  step,
    input  bcd8_t top,
    output bcd8_t val,
    output logic  wrap
);
    bcd8_t q;

    assign val  = q;
    assign wrap = step && (q == top);

    always_ff @(posedge clk) begin
        if (rst)       q <= RST_VAL;
        else if (ld)   q <= ld_val;
        else if (step) q <= (q == top) ? LO : bcd_step(q);
    end

    // R2 R5 R7: a field at its top value restarts at its low value
    assert_field_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!ld && wrap) |=> (val == LO));
    // R11: no step and no load leaves the field unchanged
    assert_field_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step) |=> $stable(val));
endmodule

// File: rtl/clkcal_hour.sv
`timescale 1ns/1ps
module clkcal_hour import clkcal_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  logic  step,
    output bcd8_t hr,
    output logic  day_carry
);
    bcd8_t q;
    bcd8_t nxt;

    assign hr = q;

    always_comb begin
        nxt       = q;
        day_carry = 1'b0;
        if (step) begin
            if (q[7]) begin
                case (q[4:0])
                    5'h11: begin
                        nxt[4:0]  = 5'h12;
                        nxt[5]    = ~q[5];
                        day_carry = q[5];
                    end
                    5'h12:   nxt[4:0] = 5'h01;
                    default: nxt[4:0] = (q[3:0] == 4'h9) ? 5'h10 : {q[4], q[3:0] + 4'h1};
                endcase
            end else begin
                if (q[5:0] == 6'h23) begin
                    nxt[5:0]  = 6'h00;
                    day_carry = 1'b1;
                end else if (q[3:0] == 4'h9) begin
                    nxt[5:0] = {q[5:4] + 2'b01, 4'h0};
                end else begin
                    nxt[5:0] = {q[5:4], q[3:0] + 4'h1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= 8'h00;
        else if (ld) q <= ld_val & 8'hBF;
        else         q <= nxt;
    end

    // R4: the format bit only changes on a load
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (hr[7] == $past(hr[7])));
    // R4: in 12-hour mode 11 -> 12 flips the PM flag
    assert_pm_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld && step && hr[7] && hr[4:0] == 5'h11) |=> (hr[5] != $past(hr[5])));
    // R3: a 24-hour day carry leaves the hour at 00
    assert_midnight_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && day_carry && !hr[7]) |=> (hr[5:0] == 6'h00));
endmodule

// File: rtl/bcd_clock_calendar.sv
`timescale 1ns/1ps
module bcd_clock_calendar import clkcal_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_100hz,
    input  logic             cal_load_en,
    input  logic [BUS_W-1:0] cal_load,
    output logic [BUS_W-1:0] cal_rd
);
    cal_regs_t ld_img;
    cal_regs_t rd_img;
    logic      osc_stop;
    logic      rst_enable;
    logic      run;

    bcd8_t               time_q   [NUM_TIME];
    logic [NUM_TIME:0]   time_cy;
    bcd8_t               time_ld  [NUM_TIME];

    bcd8_t hour_q, dow_q, date_q, month_q, year_q;
    logic  hour_cy, dow_wrap, date_wrap, month_wrap, year_wrap;
    bcd8_t date_top;

    assign ld_img = cal_regs_t'(cal_load & KEEP_MASK);
    assign run    = tick_100hz && !osc_stop && !cal_load_en;

    assign time_ld[0] = ld_img.centi;
    assign time_ld[1] = ld_img.second;
    assign time_ld[2] = ld_img.minute;
    assign time_cy[0] = run;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_time
        clkcal_field #(.LO(8'h00), .RST_VAL(8'h00)) u_fld (
            .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val(time_ld[i]),
            .step(time_cy[i]), .top(TIME_TOP[i]),
            .val(time_q[i]), .wrap(time_cy[i+1])
        );
    end

    clkcal_hour u_hour (
        .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val(ld_img.hour),
        .step(time_cy[NUM_TIME]), .hr(hour_q), .day_carry(hour_cy)
    );

    clkcal_field #(.LO(8'h01), .RST_VAL(8'h01)) u_dow (
        .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val({5'b0, ld_img.day[2:0]}),
        .step(hour_cy), .top(8'h07), .val(dow_q), .wrap(dow_wrap)
    );

    assign date_top = month_last(month_q, year_q);

    clkcal_field #(.LO(8'h01), .RST_VAL(8'h01)) u_date (
        .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val(ld_img.date),
        .step(hour_cy), .top(date_top), .val(date_q), .wrap(date_wrap)
    );

    clkcal_field #(.LO(8'h01), .RST_VAL(8'h01)) u_month (
        .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val(ld_img.month),
        .step(date_wrap), .top(8'h12), .val(month_q), .wrap(month_wrap)
    );

    clkcal_field #(.LO(8'h00), .RST_VAL(8'h00)) u_year (
        .clk(clk), .rst(rst), .ld(cal_load_en), .ld_val(ld_img.year),
        .step(month_wrap), .top(8'h99), .val(year_q), .wrap(year_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_stop   <= 1'b0;
            rst_enable <= 1'b0;
        end else if (cal_load_en) begin
            osc_stop   <= ld_img.day[5];
            rst_enable <= ld_img.day[4];
        end
    end

    always_comb begin
        rd_img.centi  = time_q[0];
        rd_img.second = time_q[1];
        rd_img.minute = time_q[2];
        rd_img.hour   = hour_q;
        rd_img.day    = {2'b00, osc_stop, rst_enable, 4'h0} | dow_q;
        rd_img.date   = date_q;
        rd_img.month  = month_q;
        rd_img.year   = year_q;
    end

    assign cal_rd = rd_img;

    // R10: a load wins over a tick in the same cycle
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cal_load_en |=> (cal_rd == ($past(cal_load) & KEEP_MASK)));
    // R8: a stopped oscillator freezes every register
    assert_osc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cal_load_en && cal_rd[37]) |=> $stable(cal_rd));
    // R9: the always-zero bits never read as 1
    assert_zero_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (cal_rd & ~KEEP_MASK) == '0);
    // R7: year wrap only happens out of 99
    assert_year_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (year_wrap && !cal_load_en) |=> (cal_rd[63:56] == 8'h00));
    // R8: the stored flag keeps its value between loads
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cal_load_en |=> $stable(cal_rd[36]));
endmodule

// File: tb/sim_bcd_clock_calendar.sv
`timescale 1ns/1ps
module sim_bcd_clock_calendar;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_100hz;
    logic        cal_load_en;
    logic [63:0] cal_load;
    logic [63:0] cal_rd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bcd_clock_calendar u0 (
        .clk(clk), .rst(rst), .tick_100hz(tick_100hz),
        .cal_load_en(cal_load_en), .cal_load(cal_load), .cal_rd(cal_rd)
    );

    localparam int NV = 22;
    // byte order on the bus: year month date day hour minute second hundredths
    localparam logic [63:0] VIN [NV] = '{
        64'h0001_0101_0000_0005, 64'h0001_0101_0000_0009, 64'h0001_0101_0059_5999,
        64'h2405_1503_1959_5999, 64'h2405_1503_2359_5999, 64'h2405_1503_9159_5999,
        64'h2405_1503_B259_5999, 64'h2405_1503_B159_5999, 64'h2404_3003_2359_5999,
        64'h2401_3103_2359_5999, 64'h2302_2803_2359_5999, 64'h2402_2803_2359_5999,
        64'h0002_2903_2359_5999, 64'h0002_2803_2359_5999, 64'h1202_2803_2359_5999,
        64'h1002_2803_2359_5999, 64'h2409_3003_2359_5999, 64'h2411_3003_2359_5999,
        64'h2405_1507_2359_5999, 64'h9912_3105_2359_5999, 64'h2405_1513_2359_5999,
        64'h2405_3103_2359_5999
    };
    localparam logic [63:0] VEXP [NV] = '{
        64'h0001_0101_0000_0006, 64'h0001_0101_0000_0010, 64'h0001_0101_0100_0000,
        64'h2405_1503_2000_0000, 64'h2405_1604_0000_0000, 64'h2405_1503_B200_0000,
        64'h2405_1503_A100_0000, 64'h2405_1604_9200_0000, 64'h2405_0104_0000_0000,
        64'h2402_0104_0000_0000, 64'h2303_0104_0000_0000, 64'h2402_2904_0000_0000,
        64'h0003_0104_0000_0000, 64'h0002_2904_0000_0000, 64'h1202_2904_0000_0000,
        64'h1003_0104_0000_0000, 64'h2410_0104_0000_0000, 64'h2412_0104_0000_0000,
        64'h2405_1601_0000_0000, 64'h0001_0106_0000_0000, 64'h2405_1614_0000_0000,
        64'h2406_0104_0000_0000
    };
    localparam string VTAG [NV] = '{
        "R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4", "R5", "R5", "R5",
        "R6", "R6", "R6", "R6", "R5", "R5", "R5", "R7", "R7", "R8", "R5"
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic load_img(input logic [63:0] v);
        @(negedge clk);
        cal_load_en = 1'b1;
        cal_load    = v;
        tick_100hz  = 1'b0;
        @(negedge clk);
        cal_load_en = 1'b0;
    endtask

    task automatic one_tick();
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    initial begin
        rst = 1'b1; tick_100hz = 1'b0; cal_load_en = 1'b0; cal_load = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset image
        check("R1", cal_rd, 64'h0001_0101_0000_0000);

        // R11: ticks low, nothing moves
        repeat (5) @(negedge clk);
        check("R11", cal_rd, 64'h0001_0101_0000_0000);

        for (int i = 0; i < NV; i++) begin
            load_img(VIN[i]);
            one_tick();
            check(VTAG[i], cal_rd, VEXP[i]);
        end

        // R2: a run of ticks counts hundredths in BCD
        load_img(64'h0001_0101_0000_0000);
        repeat (25) one_tick();
        check("R2", cal_rd, 64'h0001_0101_0000_0025);

        // R8: stop bit set, ticks have no effect
        load_img(64'h2405_1523_1030_4050);
        repeat (10) one_tick();
        check("R8", cal_rd, 64'h2405_1523_1030_4050);

        // R9: all-ones load, zero bits cleared (stop bit also set)
        load_img(64'hFFFF_FFFF_FFFF_FFFF);
        repeat (3) one_tick();
        check("R9", cal_rd, 64'hFF1F_3F37_BF7F_7FFF);

        // R10: load arriving together with a tick is taken as is
        @(negedge clk);
        cal_load_en = 1'b1;
        cal_load    = 64'h2405_1503_1259_5999;
        tick_100hz  = 1'b1;
        @(negedge clk);
        cal_load_en = 1'b0;
        tick_100hz  = 1'b0;
        check("R10", cal_rd, 64'h2405_1503_1259_5999);

        // R11: hold after a load with no tick
        repeat (4) @(negedge clk);
        check("R11", cal_rd, 64'h2405_1503_1259_5999);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule